// File: doc/BRIEF.md
# Variable-Page Fully Associative Translation Buffer

This block translates 64-bit virtual addresses for a processor core. It holds a bank of entries. Each entry pairs a tag word with a translation word, and each entry carries its own page size. The page size decides how many low address bits the compare ignores and how the physical address is formed. A lookup presents a virtual address, the current context number, an access kind and a user-mode flag. One clock later the block gives one of four results: a hit with a physical address and permission set, a protection fault, an instruction-side miss, or a data-side miss.

Entries are loaded through an indexed write port. A miss records the missing page address, merged with the context, in a side-specific tag-access register. Other logic uses that register to refill the entry. Separate enables let the instruction side and the data side skip translation. While the core is in its reset/error state, the instruction side also skips translation. Every entry is examined on every lookup. If several entries match, the lowest index wins.

Top module: `vpage_tlb`

## Requirements
- R1: Translation-word bits 62:61 select the page size of an entry: 00 is 8 KiB, 01 is 64 KiB, 10 is 512 KiB and 11 is 4 MiB. The address compare ignores the low 13, 16, 19 or 22 virtual-address bits respectively.
- R2: An entry matches only when all three of these hold: translation-word bit 63 (valid) is set, tag bits 12:0 equal the request context, and the virtual address equals the tag above the ignored low bits.
- R3: On a hit, `rsp_pa` takes translation-word bits from inside the page and virtual-address bits from the page offset. It is then limited to bits 40:13, so bits 12:0 read as zero.
- R4: When several entries match, the entry with the lowest index supplies the result.
- R5: `req_kind` is coded 00 fetch, 01 data read, 10 data write, and 11 is treated as a data read. A user-mode request (`req_user`=1) that matches an entry with translation-word bit 2 set yields a fault and no hit.
- R6: A data write that matches an entry with translation-word bit 1 clear yields a fault. `rsp_perm` is coded bit0 read, bit1 write, bit2 execute. A data hit grants read, plus write when bit 1 is set. A fetch hit grants execute only.
- R7: A translated request that matches no entry raises `rsp_miss_i` for a fetch or `rsp_miss_d` otherwise. It loads that side's tag-access register with {va[63:13], ctx}. The other side's register keeps its value.
- R8: With `mmu_den` low, data requests bypass the entries and hit with `rsp_pa` = va[40:0] and perm read+write. With `mmu_ien` low, fetches bypass the same way with perm execute. A bypass never touches a tag-access register.
- R9: While `red_state` is high, fetches bypass as in R8, but data requests are still translated.
- R10: A write through the port takes effect for lookups issued in later cycles. A lookup issued in the same cycle as the write sees the old entry.
- R11: Reset clears the valid state of every entry, so all translated lookups miss until entries are reloaded. It also clears all response outputs and both tag-access registers.
- R12: Each request gives exactly one of hit, fault, miss_i or miss_d, with `rsp_valid`, one clock later. `rsp_pa` and `rsp_perm` are zero on a fault or a miss. In a cycle with no request, all four flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mmu_ien | input | 1 | Instruction-side translation enable |
| mmu_den | input | 1 | Data-side translation enable |
| red_state | input | 1 | Reset/error state; forces instruction-side bypass |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag word: page address and context in bits 12:0 |
| wr_tte | input | 64 | Translation word: valid, size, physical page, privileged, writable |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 64 | Virtual address |
| req_ctx | input | 13 | Current context number |
| req_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| req_user | input | 1 | Request comes from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Protection fault |
| rsp_miss_i | output | 1 | Instruction-side miss |
| rsp_miss_d | output | 1 | Data-side miss |
| rsp_pa | output | 41 | Physical address |
| rsp_perm | output | 3 | Granted permissions: bit0 read, bit1 write, bit2 execute |
| itag_access | output | 64 | Instruction-side miss tag-access value |
| dtag_access | output | 64 | Data-side miss tag-access value |

## Verification
A wrong size field, context compare or valid bit shows up on the response one clock after the affected lookup. It appears as a hit where a miss was due, or the reverse, together with a tag-access register that did or did not change. A wrong page splice or priority choice shows as a wrong `rsp_pa` in that same response cycle. Overlapping entries with different physical pages make the chosen entry visible. A stale or early write shows on the first lookup issued in the write cycle or the cycle after it.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;

   // smallest page offset width; each size step adds three bits
   localparam int unsigned BASE_SHIFT = 13;
   localparam int unsigned SIZE_STEP  = 3;
   localparam int unsigned WORD_W     = 64;

   // translation word field positions (consumed by the match logic)
   localparam int unsigned VLD_BIT  = 63;
   localparam int unsigned SZ_HI    = 62;
   localparam int unsigned SZ_LO    = 61;
   localparam int unsigned PRIV_BIT = 2;
   localparam int unsigned WEN_BIT  = 1;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_READ  = 2'b01,
      ACC_WRITE = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   localparam logic [2:0] PERM_R = 3'b001;
   localparam logic [2:0] PERM_W = 3'b010;
   localparam logic [2:0] PERM_X = 3'b100;

   // ones on the address bits that belong to the page number
   function automatic logic [WORD_W-1:0] page_keep(input logic [1:0] sz);
      logic [6:0] sh;
      sh = 7'(BASE_SHIFT) + 7'(SIZE_STEP) * 7'(sz);
      return ~((64'd1 << sh) - 64'd1);
   endfunction

endpackage

// File: rtl/vpage_tlb_store.sv
module vpage_tlb_store
   import vpage_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned VA_W    = 64,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [VA_W-1:0]                   wr_tag,
   input  logic [WORD_W-1:0]                 wr_tte,
   output logic [ENTRIES-1:0][VA_W-1:0]      tag_o,
   output logic [ENTRIES-1:0][WORD_W-1:0]    tte_o,
   output logic [ENTRIES-1:0]                vld_o
);

   logic [ENTRIES-1:0][VA_W-1:0]   tag_q;
   logic [ENTRIES-1:0][WORD_W-1:0] tte_q;
   logic [ENTRIES-1:0]             vld_q;

   // only the valid state needs a reset; the payload is don't-care while invalid
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= wr_tte[VLD_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tte_q[wr_idx] <= wr_tte;
      end
   end

   assign tag_o = tag_q;
   assign tte_o = tte_q;
   assign vld_o = vld_q;

   // R11: the cycle after reset every entry is invalid
   a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (vld_q == '0));

endmodule

// File: rtl/vpage_tlb_cmp.sv
module vpage_tlb_cmp
   import vpage_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned VA_W    = 64,
   parameter int unsigned PA_W    = 41,
   parameter int unsigned CTX_W   = 13
) (
   input  logic [ENTRIES-1:0][VA_W-1:0]   tag_i,
   input  logic [ENTRIES-1:0][WORD_W-1:0] tte_i,
   input  logic [ENTRIES-1:0]             vld_i,
   input  logic [VA_W-1:0]                va_i,
   input  logic [CTX_W-1:0]               ctx_i,
   output logic [ENTRIES-1:0]             match_o,
   output logic [ENTRIES-1:0][PA_W-1:0]   pa_o
);

   localparam logic [PA_W-1:0] PA_FRAME = ~((PA_W)'((64'd1 << BASE_SHIFT) - 64'd1));

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [1:0]        sz;
      logic [WORD_W-1:0] keep_full;
      logic [VA_W-1:0]   keep;
      logic [PA_W-1:0]   keep_pa;
      logic              ctx_eq;
      logic              va_eq;
      logic [PA_W-1:0]   spliced;

      assign sz        = tte_i[e][SZ_HI:SZ_LO];
      assign keep_full = page_keep(sz);
      assign keep      = keep_full[VA_W-1:0];
      assign keep_pa   = keep_full[PA_W-1:0];
      assign ctx_eq    = (tag_i[e][CTX_W-1:0] == ctx_i);
      assign va_eq     = (((va_i ^ tag_i[e]) & keep) == '0);
      assign match_o[e] = vld_i[e] & ctx_eq & va_eq;

      assign spliced  = (tte_i[e][PA_W-1:0] & keep_pa) | (va_i[PA_W-1:0] & ~keep_pa);
      assign pa_o[e]  = spliced & PA_FRAME;
   end

endmodule

// File: rtl/vpage_tlb_pick.sv
module vpage_tlb_pick #(
   parameter int unsigned ENTRIES = 64,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] match_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);

   // scan from the top so the lowest matching index is left standing
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   // R4: chosen entry matches and no lower entry does
   a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
      any_o |-> (match_i[idx_o] &&
                 ((match_i & ((ENTRIES'(1) << idx_o) - ENTRIES'(1))) == '0)));

   a_r4_none_means_idle: assert property (@(posedge clk) disable iff (rst)
      !any_o |-> (match_i == '0));

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
   import vpage_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned VA_W    = 64,
   parameter int unsigned PA_W    = 41,
   parameter int unsigned CTX_W   = 13,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mmu_ien,
   input  logic              mmu_den,
   input  logic              red_state,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_tag,
   input  logic [63:0]       wr_tte,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [1:0]        req_kind,
   input  logic              req_user,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_fault,
   output logic              rsp_miss_i,
   output logic              rsp_miss_d,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [2:0]        rsp_perm,
   output logic [VA_W-1:0]   itag_access,
   output logic [VA_W-1:0]   dtag_access
);

   // elaboration checks on the parameter set
   if (CTX_W != BASE_SHIFT) begin : g_bad_ctx
      $error("context width must equal the smallest page offset width");
   end
   if (PA_W <= BASE_SHIFT + 3 * SIZE_STEP || PA_W > SZ_LO) begin : g_bad_pa
      $error("physical width must exceed the largest page offset and stay below the size field");
   end
   if (VA_W < PA_W || VA_W > WORD_W) begin : g_bad_va
      $error("virtual width must lie between physical width and the word width");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("at least two entries are required");
   end

   logic [ENTRIES-1:0][VA_W-1:0]   tag_w;
   logic [ENTRIES-1:0][WORD_W-1:0] tte_w;
   logic [ENTRIES-1:0]             vld_w;
   logic [ENTRIES-1:0]             match_w;
   logic [ENTRIES-1:0][PA_W-1:0]   pa_w;
   logic                           any_w;
   logic [IDX_W-1:0]               sel_w;

   vpage_tlb_store #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_store (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_tag (wr_tag),
      .wr_tte (wr_tte),
      .tag_o  (tag_w),
      .tte_o  (tte_w),
      .vld_o  (vld_w)
   );

   vpage_tlb_cmp #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)) u_cmp (
      .tag_i   (tag_w),
      .tte_i   (tte_w),
      .vld_i   (vld_w),
      .va_i    (req_va),
      .ctx_i   (req_ctx),
      .match_o (match_w),
      .pa_o    (pa_w)
   );

   vpage_tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
      .clk     (clk),
      .rst     (rst),
      .match_i (match_w),
      .any_o   (any_w),
      .idx_o   (sel_w)
   );

   // request decode
   logic              is_fetch;
   logic              is_write;
   logic              bypass;
   logic [WORD_W-1:0] sel_tte;
   logic [PA_W-1:0]   sel_pa;
   logic              priv_viol;
   logic              wr_viol;
   logic [2:0]        hit_perm;
   logic [2:0]        byp_perm;
   logic [VA_W-1:0]   miss_tag;

   assign is_fetch  = (req_kind == ACC_FETCH);
   assign is_write  = (req_kind == ACC_WRITE);
   assign bypass    = is_fetch ? (!mmu_ien || red_state) : !mmu_den;
   assign sel_tte   = tte_w[sel_w];
   assign sel_pa    = pa_w[sel_w];
   assign priv_viol = sel_tte[PRIV_BIT] & req_user;
   assign wr_viol   = is_write & ~sel_tte[WEN_BIT];
   assign hit_perm  = is_fetch ? PERM_X : (sel_tte[WEN_BIT] ? (PERM_R | PERM_W) : PERM_R);
   assign byp_perm  = is_fetch ? PERM_X : (PERM_R | PERM_W);
   assign miss_tag  = {req_va[VA_W-1:CTX_W], req_ctx};

   // registered response
   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_fault   <= 1'b0;
         rsp_miss_i  <= 1'b0;
         rsp_miss_d  <= 1'b0;
         rsp_pa      <= '0;
         rsp_perm    <= '0;
         itag_access <= '0;
         dtag_access <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_hit    <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_miss_i <= 1'b0;
         rsp_miss_d <= 1'b0;
         rsp_pa     <= '0;
         rsp_perm   <= '0;
         if (req_valid) begin
            if (bypass) begin
               rsp_hit  <= 1'b1;
               rsp_pa   <= req_va[PA_W-1:0];
               rsp_perm <= byp_perm;
            end else if (any_w) begin
               if (priv_viol || wr_viol) begin
                  rsp_fault <= 1'b1;
               end else begin
                  rsp_hit  <= 1'b1;
                  rsp_pa   <= sel_pa;
                  rsp_perm <= hit_perm;
               end
            end else if (is_fetch) begin
               rsp_miss_i  <= 1'b1;
               itag_access <= miss_tag;
            end else begin
               rsp_miss_d  <= 1'b1;
               dtag_access <= miss_tag;
            end
         end
      end
   end

   // R12: outcomes never overlap
   a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rsp_hit, rsp_fault, rsp_miss_i, rsp_miss_d}));

   // R12: a request is answered on the next clock with exactly one outcome
   a_r12_answer_next: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> (rsp_valid &&
                     $countones({rsp_hit, rsp_fault, rsp_miss_i, rsp_miss_d}) == 1));

   // R7: a data miss records the context that was presented
   a_r7_dmiss_ctx: assert property (@(posedge clk) disable iff (rst)
      rsp_miss_d |-> (dtag_access[CTX_W-1:0] == $past(req_ctx)));

   // R9: fetches during the reset/error state are never translated
   a_r9_red_fetch_bypass: assert property (@(posedge clk) disable iff (rst)
      (req_valid && red_state && req_kind == ACC_FETCH) |=> (rsp_hit && !rsp_miss_i));

endmodule

// File: tb/tb_vpage_tlb.sv
module tb_vpage_tlb;
   localparam int N = 64;

   logic        clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst, mmu_ien, mmu_den, red_state, wr_en, req_valid, req_user;
   logic [5:0]  wr_idx;
   logic [63:0] wr_tag, wr_tte, req_va;
   logic [12:0] req_ctx;
   logic [1:0]  req_kind;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss_i, rsp_miss_d;
   logic [40:0] rsp_pa;
   logic [2:0]  rsp_perm;
   logic [63:0] itag_access, dtag_access;

   vpage_tlb #(.ENTRIES(N), .VA_W(64), .PA_W(41), .CTX_W(13)) dut (.*);

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference state
   logic [63:0] m_tag [N];
   logic [63:0] m_tte [N];
   logic        m_vld [N];
   logic [63:0] m_itag, m_dtag;

   logic        e_valid, e_hit, e_fault, e_mi, e_md;
   logic [40:0] e_pa;
   logic [2:0]  e_perm;

   function automatic logic [63:0] mk_tte(input logic v, input logic [1:0] sz,
                                          input logic [63:0] pa, input logic priv,
                                          input logic wen);
      return {v, sz, 61'd0} | (pa & 64'h0000_01FF_FFFF_E000) |
             {61'd0, priv, wen, 1'b0};
   endfunction

   function automatic logic [63:0] model_mask(input logic [1:0] sz);
      int sh;
      sh = 13 + 3 * int'(sz);
      return ~((64'd1 << sh) - 64'd1);
   endfunction

   function automatic void model_eval(input logic [63:0] va, input logic [12:0] ctx,
                                      input logic [1:0] kind, input logic user);
      logic        byp, found;
      int          sel;
      logic [63:0] mk, pa64;
      e_valid = 1; e_hit = 0; e_fault = 0; e_mi = 0; e_md = 0; e_pa = '0; e_perm = '0;
      found = 0; sel = 0;
      byp = (kind == 2'b00) ? (!mmu_ien || red_state) : !mmu_den;
      if (byp) begin
         e_hit = 1; e_pa = va[40:0];
         e_perm = (kind == 2'b00) ? 3'b100 : 3'b011;
         return;
      end
      for (int i = 0; i < N; i++) begin
         if (!found && m_vld[i] && m_tag[i][12:0] == ctx) begin
            mk = model_mask(m_tte[i][62:61]);
            if (((va ^ m_tag[i]) & mk) == 64'd0) begin
               found = 1; sel = i;
            end
         end
      end
      if (!found) begin
         if (kind == 2'b00) begin e_mi = 1; m_itag = {va[63:13], ctx}; end
         else               begin e_md = 1; m_dtag = {va[63:13], ctx}; end
         return;
      end
      if ((m_tte[sel][2] && user) || (kind == 2'b10 && !m_tte[sel][1])) begin
         e_fault = 1;
         return;
      end
      mk   = model_mask(m_tte[sel][62:61]);
      pa64 = ((m_tte[sel] & mk) | (va & ~mk)) & 64'h0000_01FF_FFFF_E000;
      e_hit  = 1;
      e_pa   = pa64[40:0];
      e_perm = (kind == 2'b00) ? 3'b100 : (m_tte[sel][1] ? 3'b011 : 3'b001);
   endfunction

   task automatic check(input string req);
      total++;
      if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_fault !== e_fault ||
          rsp_miss_i !== e_mi || rsp_miss_d !== e_md || rsp_pa !== e_pa ||
          rsp_perm !== e_perm || itag_access !== m_itag || dtag_access !== m_dtag) begin
         bad++;
         $display("FAIL %s: act v=%0b h=%0b f=%0b mi=%0b md=%0b pa=%h perm=%b it=%h dt=%h | exp v=%0b h=%0b f=%0b mi=%0b md=%0b pa=%h perm=%b it=%h dt=%h",
                  req, rsp_valid, rsp_hit, rsp_fault, rsp_miss_i, rsp_miss_d, rsp_pa,
                  rsp_perm, itag_access, dtag_access, e_valid, e_hit, e_fault, e_mi,
                  e_md, e_pa, e_perm, m_itag, m_dtag);
      end
   endtask

   task automatic model_write(input int idx, input logic [63:0] tag, input logic [63:0] tte);
      m_tag[idx] = tag; m_tte[idx] = tte; m_vld[idx] = tte[63];
   endtask

   task automatic write_entry(input int idx, input logic [63:0] tag, input logic [63:0] tte);
      @(negedge clk);
      wr_en = 1; wr_idx = 6'(idx); wr_tag = tag; wr_tte = tte;
      @(negedge clk);
      wr_en = 0;
      model_write(idx, tag, tte);
   endtask

   task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                         input logic [1:0] kind, input logic user, input string req);
      @(negedge clk);
      req_valid = 1; req_va = va; req_ctx = ctx; req_kind = kind; req_user = user;
      model_eval(va, ctx, kind, user);
      @(negedge clk);
      check(req);
      req_valid = 0;
   endtask

   task automatic do_reset();
      rst = 1;
      repeat (3) @(negedge clk);
      rst = 0;
      for (int i = 0; i < N; i++) m_vld[i] = 0;
      m_itag = '0; m_dtag = '0;
   endtask

   localparam logic [12:0] CA = 13'h0A5;
   localparam logic [12:0] CB = 13'h133;

   initial begin
      rst = 1; mmu_ien = 1; mmu_den = 1; red_state = 0; wr_en = 0; wr_idx = '0;
      wr_tag = '0; wr_tte = '0; req_valid = 0; req_va = '0; req_ctx = '0;
      req_kind = '0; req_user = 0;
      for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_tte[i] = '0; m_vld[i] = 0; end
      m_itag = '0; m_dtag = '0;
      void'($urandom(32'd4242));
      do_reset();

      // R11: outputs after reset
      @(negedge clk);
      e_valid = 0; e_hit = 0; e_fault = 0; e_mi = 0; e_md = 0; e_pa = '0; e_perm = '0;
      check("R11 reset state");

      // R11: a loaded entry is forgotten by reset
      write_entry(0, 64'h0000_0010_0000_0000 | 64'(CA),
                  mk_tte(1, 2'b00, 64'h0000_0000_0AAA_A000, 0, 1));
      lookup(64'h0000_0010_0000_0123, CA, 2'b01, 0, "R11 pre-reset hit");
      do_reset();
      lookup(64'h0000_0010_0000_0123, CA, 2'b01, 0, "R11 miss after reset");

      // R1: 64K entry ignores bits 15:13, compares bit 16
      write_entry(5, 64'h0000_0040_1234_0000 | 64'(CA),
                  mk_tte(1, 2'b01, 64'h0000_0123_4560_0000, 0, 1));
      lookup(64'h0000_0040_1234_EABC, CA, 2'b01, 0, "R1 64K offset hit");
      lookup(64'h0000_0040_1235_0000, CA, 2'b01, 0, "R1 64K page miss");
      // R1: 4M entry ignores bit 21
      write_entry(7, 64'h0000_0080_0040_0000 | 64'(CA),
                  mk_tte(1, 2'b11, 64'h0000_00AB_CC40_0000, 0, 0));
      lookup(64'h0000_0080_007F_FFFF, CA, 2'b00, 0, "R1 4M offset hit");
      lookup(64'h0000_0080_0080_0000, CA, 2'b00, 0, "R1 4M page miss");

      // R2: context and valid both required
      lookup(64'h0000_0040_1234_0100, CB, 2'b01, 0, "R2 context mismatch");
      write_entry(5, 64'h0000_0040_1234_0000 | 64'(CA),
                  mk_tte(0, 2'b01, 64'h0000_0123_4560_0000, 0, 1));
      lookup(64'h0000_0040_1234_0100, CA, 2'b01, 0, "R2 invalid entry");

      // R3: 512K splice and low-bit clearing
      write_entry(12, 64'h0000_0000_3608_0000 | 64'(CB),
                  mk_tte(1, 2'b10, 64'h0000_01F0_0F00_0000, 0, 1));
      lookup(64'h0000_0000_360F_FFFF, CB, 2'b01, 0, "R3 512K splice");

      // R4: overlapping entries, lower index wins
      write_entry(9, 64'h0000_0200_0000_0000 | 64'(CA),
                  mk_tte(1, 2'b00, 64'h0000_0099_9990_0000, 0, 1));
      write_entry(3, 64'h0000_0200_0000_0000 | 64'(CA),
                  mk_tte(1, 2'b11, 64'h0000_0033_3300_0000, 0, 0));
      lookup(64'h0000_0200_0000_1234, CA, 2'b01, 0, "R4 lowest index");

      // R5: privileged page
      write_entry(20, 64'h0000_0300_0000_0000 | 64'(CB),
                  mk_tte(1, 2'b00, 64'h0000_0055_5554_0000, 1, 1));
      lookup(64'h0000_0300_0000_0040, CB, 2'b00, 1, "R5 user fault");
      lookup(64'h0000_0300_0000_0040, CB, 2'b00, 0, "R5 privileged hit");

      // R6: write permission and granted perms
      write_entry(21, 64'h0000_0310_0000_0000 | 64'(CB),
                  mk_tte(1, 2'b00, 64'h0000_0066_6660_0000, 0, 0));
      lookup(64'h0000_0310_0000_0008, CB, 2'b10, 0, "R6 write fault");
      lookup(64'h0000_0310_0000_0008, CB, 2'b01, 1, "R6 read-only perm");
      lookup(64'h0000_0310_0000_0008, CB, 2'b11, 0, "R6 reserved kind as read");
      lookup(64'h0000_0300_0000_0008, CB, 2'b10, 0, "R6 writable perm");
      lookup(64'h0000_0310_0000_0008, CB, 2'b00, 0, "R6 fetch exec only");

      // R7: side-specific miss capture
      lookup(64'h1234_5678_9ABC_DEF0, CA, 2'b10, 0, "R7 data miss tag");
      lookup(64'h0FED_CBA9_8765_4321, CB, 2'b00, 0, "R7 fetch miss tag");

      // R8: bypass
      mmu_den = 0;
      lookup(64'hFFFF_FFFF_FFFF_FFFF, CA, 2'b10, 1, "R8 data bypass");
      mmu_den = 1; mmu_ien = 0;
      lookup(64'h0000_0ABC_1234_5677, CA, 2'b00, 0, "R8 fetch bypass");
      mmu_ien = 1;

      // R9: reset/error state bypasses fetches only
      red_state = 1;
      lookup(64'h0000_0777_0000_1111, CA, 2'b00, 0, "R9 red fetch bypass");
      lookup(64'h0000_0777_0000_1111, CA, 2'b01, 0, "R9 red data translated");
      red_state = 0;

      // R10: write and lookup in the same cycle
      @(negedge clk);
      wr_en = 1; wr_idx = 6'd40; wr_tag = 64'h0000_0500_0000_0000 | 64'(CA);
      wr_tte = mk_tte(1, 2'b00, 64'h0000_0012_3450_0000, 0, 1);
      req_valid = 1; req_va = 64'h0000_0500_0000_0010; req_ctx = CA; req_kind = 2'b01;
      req_user = 0;
      model_eval(req_va, CA, 2'b01, 0);
      @(negedge clk);
      check("R10 same-cycle sees old");
      wr_en = 0; req_valid = 0;
      model_write(40, 64'h0000_0500_0000_0000 | 64'(CA),
                  mk_tte(1, 2'b00, 64'h0000_0012_3450_0000, 0, 1));
      lookup(64'h0000_0500_0000_0010, CA, 2'b01, 0, "R10 next lookup sees new");

      // R12: idle cycle
      @(negedge clk);
      e_valid = 0; e_hit = 0; e_fault = 0; e_mi = 0; e_md = 0; e_pa = '0; e_perm = '0;
      check("R12 idle no flags");

      // random: fill all entries then mix lookups
      for (int i = 0; i < N; i++) begin
         logic [63:0] tg, pa;
         tg = 64'h0000_0040_0000_0000 | (64'($urandom) & 64'h0FFF_E000);
         pa = {32'($urandom), 32'($urandom)};
         write_entry(i, tg | 64'((($urandom % 2) == 0) ? 13'h011 : 13'h022),
                     mk_tte(($urandom % 10) != 0, 2'($urandom), pa,
                            ($urandom % 4) == 0, ($urandom % 2) == 0));
      end
      for (int k = 0; k < 400; k++) begin
         int          j;
         logic [63:0] va;
         logic [12:0] cx;
         j  = int'($urandom % N);
         va = {m_tag[j][63:13], 13'd0} ^
              (64'($urandom) & ((($urandom % 2) == 0) ? 64'h1FFF : 64'h3F_FFFF));
         cx = (($urandom % 7) == 0) ? 13'h033 : m_tag[j][12:0];
         red_state = (($urandom % 10) == 0);
         mmu_den   = (($urandom % 12) != 0);
         mmu_ien   = (($urandom % 12) != 0);
         lookup(va, cx, 2'($urandom % 3), 1'($urandom), "R2/R3/R5/R6/R7 random");
      end
      red_state = 0; mmu_den = 1; mmu_ien = 1;

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: act=timeout exp=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule